// File: doc/BRIEF.md
# Prescaled real-time counter

This block keeps time from a slow tick clock with two cascaded counters: a 15-bit pre-counter that advances on every running tick and a 32-bit main counter that advances on selected pre-counter states. The main counter's advance can come from either of two sources. In divider mode it is a power-of-two tap of the pre-counter, with the ratio chosen from 1 up to 32768. In match mode it advances when the pre-counter equals the low 15 bits of the first compare value. Each counter can also be told to restart from zero once it reaches its compare value. The first compare value sets the pre-counter's wrap point and the second sets the main counter's.

Software loads either counter and the configuration word through write strobes. A 16-bit key opens a lock, and any other key closes it. While the lock is closed, all of those writes are dropped. A packed readout joins the low main-counter bits and the pre-counter into one word, so both can be captured in a single read. Counting stops when `enable_i` is low. It also stops while the debug-halt input is high, unless the configuration allows the counter to keep running through a halt.

Top module: `rtc_tick_core`

## Requirements
- R1: After reset the pre-counter and main counter are zero, the configuration word reads 8'h05 (divide by 32, divider mode, no wraps, freeze on halt) and the lock is open.
- R2: While running, the pre-counter increases by one every clock and rolls from 15'h7FFF to 0 when its wrap option is off.
- R3: In divider mode (cfg bit 4 = 0) the main counter advances in each cycle where the low N bits of the pre-counter are all ones, N being cfg bits [3:0]; N = 0 advances it every running cycle.
- R4: In match mode (cfg bit 4 = 1) the main counter advances in the cycle where the pre-counter equals the low 15 bits of `cmp0_i`.
- R5: With cfg bit 5 set, a pre-counter equal to the low 15 bits of `cmp0_i` goes to zero on the next running cycle instead of incrementing.
- R6: With cfg bit 6 set, an advance while the main counter equals `cmp1_i` loads zero instead of incrementing.
- R7: Both counters hold while `enable_i` is low, or while `dbg_halt_i` is high and cfg bit 7 is 0. With cfg bit 7 = 1 a halt has no effect.
- R8: `comb_o` equals main counter bits [16:0] above the 15-bit pre-counter.
- R9: With the lock open, a counter or pre-counter write appears on the output in the next cycle and wins over an advance in the same cycle. The main counter rolls from 32'hFFFFFFFF to 0.
- R10: A lock write of 16'h5A17 opens the lock and any other value closes it. While the lock is closed, pre-counter, counter and configuration writes leave those registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Counting enable |
| dbg_halt_i | input | 1 | Debug halt request |
| lock_we_i | input | 1 | Lock register write strobe |
| lock_wdata_i | input | 16 | Lock key |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration word: [3:0] divider, [4] match mode, [5] pre wrap, [6] counter wrap, [7] run in halt |
| pre_we_i | input | 1 | Pre-counter write strobe |
| pre_wdata_i | input | 15 | Pre-counter load value |
| cnt_we_i | input | 1 | Main counter write strobe |
| cnt_wdata_i | input | 32 | Main counter load value |
| cmp0_i | input | 32 | First compare value (match and pre-counter wrap) |
| cmp1_i | input | 32 | Second compare value (main counter wrap) |
| pre_o | output | 15 | Pre-counter |
| cnt_o | output | 32 | Main counter |
| comb_o | output | 32 | Packed counter readout |
| cfg_o | output | 8 | Configuration word |
| locked_o | output | 1 | Lock closed |

## Verification
The divider is tested at ratios 32, 1 and 8, which show whether the tap mask is sized from the field or is off by one. A pre-counter load just below the 15-bit limit exposes the rollover. Match mode is tested first without and then with the pre-counter wrap, which separates a tick that happens once per 32768 cycles from one that repeats every compare-plus-one cycles. The counter wrap is tested with a small compare value. The tests also cover the enable and halt combinations, a counter load in a cycle that also advances, and a closed lock that receives writes to all three registers.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

    typedef enum logic {
        TICK_DIV   = 1'b0,
        TICK_MATCH = 1'b1
    } tick_mode_e;

    typedef struct packed {
        logic       run_in_halt;
        logic       cnt_wrap;
        logic       pre_wrap;
        tick_mode_e mode;
        logic [3:0] div_sel;
    } rtc_cfg_t;

    localparam int unsigned CFG_W = $bits(rtc_cfg_t);

endpackage

// File: rtl/rtc_lock_cfg.sv
module rtc_lock_cfg
    import rtc_core_pkg::*;
#(
    parameter int unsigned    KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5A17,
    parameter logic [7:0]     CFG_RESET  = 8'h05
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lock_we_i,
    input  logic [KEY_W-1:0] lock_wdata_i,
    input  logic             cfg_we_i,
    input  rtc_cfg_t         cfg_wdata_i,
    output rtc_cfg_t         cfg_o,
    output logic             locked_o,
    output logic             wr_ok_o
);

    typedef struct packed {
        logic     locked;
        rtc_cfg_t cfg;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i && !st_q.locked) begin
            st_d.cfg = cfg_wdata_i;
        end
        if (lock_we_i) begin
            st_d.locked = (lock_wdata_i != UNLOCK_KEY);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.locked <= 1'b0;
            st_q.cfg    <= rtc_cfg_t'(CFG_RESET);
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o    = st_q.cfg;
    assign locked_o = st_q.locked;
    assign wr_ok_o  = !st_q.locked;

endmodule

// File: rtl/rtc_precount.sv
module rtc_precount
    import rtc_core_pkg::*;
#(
    parameter int unsigned PRE_W = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  tick_mode_e       mode_i,
    input  logic [3:0]       div_sel_i,
    input  logic             wrap_en_i,
    input  logic [PRE_W-1:0] match_i,
    input  logic             wr_en_i,
    input  logic [PRE_W-1:0] wr_data_i,
    output logic [PRE_W-1:0] pre_o,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t          st_d, st_q;
    logic [PRE_W-1:0] tap_mask;
    logic             hit;
    logic             tap;

    always_comb begin
        tap_mask = (PRE_W'(1) << div_sel_i) - PRE_W'(1);
        hit      = (st_q.pre == match_i);
        tap      = ((st_q.pre & tap_mask) == tap_mask);
        tick_o   = run_i && ((mode_i == TICK_MATCH) ? hit : tap);

        st_d = st_q;
        if (run_i) begin
            if (wrap_en_i && hit) begin
                st_d.pre = '0;
            end else begin
                st_d.pre = st_q.pre + PRE_W'(1);
            end
        end
        if (wr_en_i) begin
            st_d.pre = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pre_o = st_q.pre;

endmodule

// File: rtl/rtc_maincount.sv
module rtc_maincount #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             wrap_en_i,
    input  logic [CNT_W-1:0] wrap_val_i,
    input  logic             wr_en_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            if (wrap_en_i && (st_q.cnt == wrap_val_i)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
        if (wr_en_i) begin
            st_d.cnt = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/rtc_tick_core.sv
module rtc_tick_core
    import rtc_core_pkg::*;
#(
    parameter int unsigned      PRE_W      = 15,
    parameter int unsigned      CNT_W      = 32,
    parameter int unsigned      KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5A17
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             enable_i,
    input  logic             dbg_halt_i,
    input  logic             lock_we_i,
    input  logic [KEY_W-1:0] lock_wdata_i,
    input  logic             cfg_we_i,
    input  logic [7:0]       cfg_wdata_i,
    input  logic             pre_we_i,
    input  logic [PRE_W-1:0] pre_wdata_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic [CNT_W-1:0] cmp0_i,
    input  logic [CNT_W-1:0] cmp1_i,
    output logic [PRE_W-1:0] pre_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] comb_o,
    output logic [7:0]       cfg_o,
    output logic             locked_o
);

    localparam int unsigned COMB_HI = CNT_W - PRE_W;

    rtc_cfg_t cfg;
    logic     wr_ok;
    logic     running;
    logic     tick;
    logic     unused_cmp0;

    assign unused_cmp0 = ^cmp0_i[CNT_W-1:PRE_W];

    rtc_lock_cfg #(
        .KEY_W      (KEY_W),
        .UNLOCK_KEY (UNLOCK_KEY),
        .CFG_RESET  (8'h05)
    ) u_lock (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .lock_we_i    (lock_we_i),
        .lock_wdata_i (lock_wdata_i),
        .cfg_we_i     (cfg_we_i),
        .cfg_wdata_i  (rtc_cfg_t'(cfg_wdata_i)),
        .cfg_o        (cfg),
        .locked_o     (locked_o),
        .wr_ok_o      (wr_ok)
    );

    assign running = enable_i && (!dbg_halt_i || cfg.run_in_halt);

    rtc_precount #(
        .PRE_W (PRE_W)
    ) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (running),
        .mode_i    (cfg.mode),
        .div_sel_i (cfg.div_sel),
        .wrap_en_i (cfg.pre_wrap),
        .match_i   (cmp0_i[PRE_W-1:0]),
        .wr_en_i   (pre_we_i && wr_ok),
        .wr_data_i (pre_wdata_i),
        .pre_o     (pre_o),
        .tick_o    (tick)
    );

    rtc_maincount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (tick),
        .wrap_en_i  (cfg.cnt_wrap),
        .wrap_val_i (cmp1_i),
        .wr_en_i    (cnt_we_i && wr_ok),
        .wr_data_i  (cnt_wdata_i),
        .cnt_o      (cnt_o)
    );

    assign comb_o = {cnt_o[COMB_HI-1:0], pre_o};
    assign cfg_o  = cfg;

endmodule

// File: rtl/rtc_tick_core_chk.sv
module rtc_tick_core_chk #(
    parameter int unsigned      PRE_W      = 15,
    parameter int unsigned      CNT_W      = 32,
    parameter int unsigned      KEY_W      = 16,
    parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'h5A17
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic             dbg_halt_i,
    input logic             lock_we_i,
    input logic [KEY_W-1:0] lock_wdata_i,
    input logic             pre_we_i,
    input logic             cnt_we_i,
    input logic [CNT_W-1:0] cnt_wdata_i,
    input logic [CNT_W-1:0] cmp0_i,
    input logic [CNT_W-1:0] cmp1_i,
    input logic [PRE_W-1:0] pre_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic [7:0]       cfg_o,
    input logic             locked_o
);

    logic run_w;
    logic pre_load;
    logic cnt_load;
    logic pre_hit;
    logic unused_hi;

    assign run_w     = enable_i && (!dbg_halt_i || cfg_o[7]);
    assign pre_load  = pre_we_i && !locked_o;
    assign cnt_load  = cnt_we_i && !locked_o;
    assign pre_hit   = (pre_o == cmp0_i[PRE_W-1:0]);
    assign unused_hi = ^cmp0_i[CNT_W-1:PRE_W];

    // R7
    pre_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_w && !pre_load) |=> $stable(pre_o));

    // R7
    cnt_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_w && !cnt_load) |=> $stable(cnt_o));

    // R5
    pre_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && cfg_o[5] && pre_hit && !pre_load) |=> (pre_o == '0));

    // R6
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && cfg_o[4] && cfg_o[6] && pre_hit && (cnt_o == cmp1_i) && !cnt_load)
        |=> (cnt_o == '0));

    // R9
    cnt_load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_load |=> (cnt_o == $past(cnt_wdata_i)));

    // R10
    key_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_we_i && (lock_wdata_i == UNLOCK_KEY)) |=> !locked_o);

    // R10
    bad_key_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lock_we_i && (lock_wdata_i != UNLOCK_KEY)) |=> locked_o);

    // R10
    cfg_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        locked_o |=> $stable(cfg_o));

endmodule

bind rtc_tick_core rtc_tick_core_chk #(
    .PRE_W      (PRE_W),
    .CNT_W      (CNT_W),
    .KEY_W      (KEY_W),
    .UNLOCK_KEY (UNLOCK_KEY)
) u_chk (.*);

// File: tb/rtc_tick_core_tb_top.sv
module rtc_tick_core_tb_top;

    localparam logic [15:0] KEY = 16'h5A17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        halt = 1'b0;
    logic        lock_we = 1'b0;
    logic [15:0] lock_wd = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wd = '0;
    logic        pre_we = 1'b0;
    logic [14:0] pre_wd = '0;
    logic        cnt_we = 1'b0;
    logic [31:0] cnt_wd = '0;
    logic [31:0] cmp0 = '0;
    logic [31:0] cmp1 = '0;
    logic [14:0] pre_o;
    logic [31:0] cnt_o;
    logic [31:0] comb_o;
    logic [7:0]  cfg_o;
    logic        locked_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    bit    live = 1'b0;
    string cur_req = "R1";

    int     m_pre;
    longint m_cnt;
    int     m_cfg;
    bit     m_lock;

    always #4 clk = ~clk;

    rtc_tick_core dut_i (
        .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .dbg_halt_i(halt),
        .lock_we_i(lock_we), .lock_wdata_i(lock_wd),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd),
        .pre_we_i(pre_we), .pre_wdata_i(pre_wd),
        .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wd),
        .cmp0_i(cmp0), .cmp1_i(cmp1),
        .pre_o(pre_o), .cnt_o(cnt_o), .comb_o(comb_o),
        .cfg_o(cfg_o), .locked_o(locked_o)
    );

    // Reference model: behavioural, one update per tick clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = 0; m_cnt = 0; m_cfg = 'h05; m_lock = 0;
        end else begin
            int     np, div, c0;
            longint nc;
            bit     run, adv;
            np  = m_pre; nc = m_cnt;
            run = enable && (!halt || m_cfg[7]);
            div = 1 << (m_cfg & 15);
            c0  = cmp0 % 32768;
            if (m_cfg[4]) adv = run && (m_pre == c0);
            else          adv = run && ((m_pre % div) == div - 1);
            if (run) np = (m_cfg[5] && m_pre == c0) ? 0 : (m_pre + 1) % 32768;
            if (adv) nc = (m_cfg[6] && m_cnt == longint'(cmp1)) ? 0 : (m_cnt + 1) % 64'h1_0000_0000;
            if (!m_lock) begin
                if (pre_we) np = pre_wd;
                if (cnt_we) nc = cnt_wd;
                if (cfg_we) m_cfg = cfg_wd;
            end
            if (lock_we) m_lock = (lock_wd != KEY);
            m_pre = np; m_cnt = nc;
        end
    end

    task automatic check(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (live && rst_n) begin
            check(cur_req, "pre-counter", longint'(pre_o), longint'(m_pre));
            check(cur_req, "main counter", longint'(cnt_o), m_cnt);
            check(cur_req, "config", longint'(cfg_o), longint'(m_cfg));
            check(cur_req, "lock", longint'(locked_o), longint'(m_lock));
            check("R8", "packed readout", longint'(comb_o),
                  ((m_cnt % 131072) * 32768) + longint'(m_pre));
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_cfg(logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wd = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic put_pre(logic [14:0] v);
        @(negedge clk); pre_we = 1'b1; pre_wd = v;
        @(negedge clk); pre_we = 1'b0;
    endtask

    task automatic put_cnt(logic [31:0] v);
        @(negedge clk); cnt_we = 1'b1; cnt_wd = v;
        @(negedge clk); cnt_we = 1'b0;
    endtask

    task automatic put_lock(logic [15:0] v);
        @(negedge clk); lock_we = 1'b1; lock_wd = v;
        @(negedge clk); lock_we = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "pre-counter", longint'(pre_o), 0);
        check("R1", "main counter", longint'(cnt_o), 0);
        check("R1", "config", longint'(cfg_o), 'h05);
        check("R1", "lock", longint'(locked_o), 0);
        rst_n = 1'b1;
        live  = 1'b1;

        cur_req = "R3"; enable = 1'b1;
        idle(130);
        put_cfg(8'h00); idle(20);
        put_cfg(8'h03); idle(40);

        cur_req = "R2";
        put_pre(15'h7FF0); idle(40);

        cur_req = "R4"; cmp0 = 32'hABCD_000A;
        put_pre(15'h0000); put_cfg(8'h10); idle(60);
        cur_req = "R5";
        put_cfg(8'h30); idle(60);

        cur_req = "R6"; cmp1 = 32'd5;
        put_cfg(8'h70); put_cnt(32'd0); idle(120);

        cur_req = "R7";
        put_cfg(8'h02);
        enable = 1'b0; idle(10);
        enable = 1'b1; halt = 1'b1; idle(10);
        put_cfg(8'h82); idle(10);
        halt = 1'b0;

        cur_req = "R9";
        put_cfg(8'h00); put_cnt(32'hFFFF_FFF0); idle(30);
        put_pre(15'h1234); idle(5);

        cur_req = "R10";
        put_lock(16'h1234);
        check("R10", "lock after bad key", longint'(locked_o), 1);
        put_pre(15'h0100); put_cnt(32'h0000_0777); put_cfg(8'h05); idle(5);
        check("R10", "config while locked", longint'(cfg_o), 'h00);
        put_lock(KEY);
        check("R10", "lock after key", longint'(locked_o), 0);
        put_cnt(32'h0000_0777); put_cfg(8'h01); idle(10);

        live = 1'b0;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule